// File: doc/BRIEF.md
# Variable-Width CRC Input Word FIFO

This block sits in front of a programmable CRC shift engine and gathers the data words that the engine will consume. Software picks a word width from 1 to 32 bits with a 5-bit code `width_cfg` = N, which gives a width of N+1. It then writes each word one byte at a time on a byte-lane port. Lane L carries bits 8L+7 down to 8L. Lower lanes are held in a staging register. A word enters the FIFO only when the lane that holds its most significant bit is written. That lane is `top = N / 8`, so the lower lanes must be written first.

The storage is a fixed 128-bit pool. The number of words it holds follows the width: 16 words for widths up to 8 bits, 8 words for widths of 9 to 16 bits, and 4 words for wider data. The shift engine reads the oldest word on `rd_data` and removes it with `pop`. The block reports the number of valid words, a full flag, an empty flag and a sticky overflow flag. Driving `enable` low flushes everything, and the width may only be changed while `enable` is low.

Occupancy is tracked by a four-state machine:
- `ST_OFF`: disabled or flushed.
- `ST_EMPTY`: enabled and holding no words.
- `ST_PART`: holding some words, but fewer than the depth.
- `ST_FULL`: count equals the depth.

The transitions are:
- any state → `ST_OFF` when `enable` is low.
- `ST_OFF` → `ST_EMPTY` when enabled, or → `ST_PART` when enabled and a word completes in the same cycle.
- `ST_EMPTY` → `ST_PART` on a push.
- `ST_PART` → `ST_EMPTY` when the last word is popped.
- `ST_PART` → `ST_FULL` when the count reaches the depth.
- `ST_FULL` → `ST_PART` on a pop.

Top module: `crc_wfifo`

## Requirements
- R1: Data bits above the configured width N+1 in any written byte are discarded, and `rd_data` never shows a bit above position N.
- R2: A write to a lane below lane `top` (= N/8) only stages that byte. A write to lane `top` completes the word from the staged bytes plus this byte, and then clears the staging register. A write to a lane above `top` is ignored.
- R3: `word_count` rises by one at the clock edge that accepts a completing write, so the new value is readable in the following cycle.
- R4: The depth is 16 words for N ≤ 7, 8 words for 8 ≤ N ≤ 15, and 4 words for N ≥ 16. `full` is high exactly when `word_count` equals that depth.
- R5: `empty` is high exactly when `word_count` is zero, and `full` and `empty` are never high together.
- R6: `rd_data` presents the oldest stored word, and reads zero when the FIFO is empty. A `pop` while not empty removes that word and lowers `word_count` by one. A `pop` while empty has no effect.
- R7: Words leave in the order in which they were completed.
- R8: While `enable` is low, the following are all forced to zero at each clock edge: the count, the stored words, the staging register and the overflow flag. Writes made while `enable` is low have no effect.
- R9: A completing write while `full` is high is dropped. It sets `overflow`, which stays set until `enable` goes low.
- R10: A completing write together with a `pop` in the same cycle leaves the count unchanged when the FIFO is not full. When the FIFO is full, the pop takes effect and the write is dropped as in R9.
- R11: After reset the outputs are: count zero, `empty` high, `full` low, `overflow` low, `rd_data` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low flushes all state |
| width_cfg | input | 5 | Width code N; word width is N+1 |
| wr_en | input | 1 | Byte write strobe |
| wr_lane | input | 2 | Byte lane being written (lane L = bits 8L+7..8L) |
| wr_byte | input | 8 | Byte data |
| pop | input | 1 | Remove the oldest word |
| rd_data | output | 32 | Oldest word, zero when empty |
| word_count | output | 5 | Number of valid words |
| full | output | 1 | Count equals the depth for the current width |
| empty | output | 1 | Count is zero |
| overflow | output | 1 | Sticky: a completed word was dropped |

## Verification
Every result is registered, so the outcome of a write or pop that is driven before an edge appears on `word_count`, `full`, `empty`, `overflow` and `rd_data` directly after that edge. The one exception is the flush: it appears one edge after `enable` falls. The bench drives inputs on the falling edge and advances its reference model at the same point. It then compares every output at the next falling edge, exactly one rising edge later. Directed checks read the outputs at that same point, after the single edge that follows the stimulus.

// File: rtl/crc_wfifo_pkg.sv
package crc_wfifo_pkg;

    parameter int DATA_W     = 32;
    parameter int CFG_W      = 5;
    parameter int LANE_W     = 8;
    parameter int STORE_BITS = 128;

    localparam int NUM_LANES  = DATA_W / LANE_W;
    localparam int LANE_IDX_W = $clog2(NUM_LANES);
    localparam int MAX_DEPTH  = STORE_BITS / LANE_W;
    localparam int CNT_W      = $clog2(MAX_DEPTH + 1);
    localparam int PTR_W      = $clog2(MAX_DEPTH);

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_EMPTY = 2'd1,
        ST_PART  = 2'd2,
        ST_FULL  = 2'd3
    } fill_state_t;

    // Words fitting the shared pool once the width is rounded up to 1, 2 or 4 lanes.
    function automatic logic [CNT_W-1:0] depth_of(input logic [CFG_W-1:0] cfg);
        int rounded;
        if (int'(cfg) >= 2 * LANE_W)
            rounded = DATA_W;
        else if (int'(cfg) >= LANE_W)
            rounded = 2 * LANE_W;
        else
            rounded = LANE_W;
        return CNT_W'(STORE_BITS / rounded);
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic [CFG_W-1:0] cfg);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++)
            m[i] = (i <= int'(cfg));
        return m;
    endfunction

    function automatic logic [LANE_IDX_W-1:0] top_lane(input logic [CFG_W-1:0] cfg);
        return LANE_IDX_W'(int'(cfg) / LANE_W);
    endfunction

endpackage

// File: rtl/crc_wfifo_stage.sv
module crc_wfifo_stage
    import crc_wfifo_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [CFG_W-1:0]      width_cfg,
    input  logic                  wr_en,
    input  logic [LANE_IDX_W-1:0] wr_lane,
    input  logic [LANE_W-1:0]     wr_byte,
    output logic                  push_req,
    output logic [DATA_W-1:0]     push_word
);

    logic [DATA_W-1:0]     stage_q;
    logic [DATA_W-1:0]     mask;
    logic [DATA_W-1:0]     merged;
    logic [LANE_IDX_W-1:0] tl;
    logic [LANE_W-1:0]     lane_mask;
    logic                  lane_ok;

    always_comb begin
        mask      = width_mask(width_cfg);
        tl        = top_lane(width_cfg);
        lane_mask = mask[wr_lane*LANE_W +: LANE_W];
        merged    = stage_q;
        merged[wr_lane*LANE_W +: LANE_W] = wr_byte & lane_mask;
        lane_ok   = enable && wr_en && (wr_lane <= tl);
        push_req  = lane_ok && (wr_lane == tl);
        push_word = merged & mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage_q <= '0;
        else if (!enable || push_req)
            stage_q <= '0;
        else if (lane_ok)
            stage_q <= merged;
    end

endmodule

// File: rtl/crc_wfifo_store.sv
module crc_wfifo_store
    import crc_wfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  depth,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_word,
    input  logic              pop_en,
    output logic [DATA_W-1:0] head_word
);

    logic [DATA_W-1:0] mem [MAX_DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p,
                                                 input logic [CNT_W-1:0] d);
        if (CNT_W'(p) == d - CNT_W'(1))
            return '0;
        return p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (!enable) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_en)
                wr_ptr <= advance(wr_ptr, depth);
            if (pop_en)
                rd_ptr <= advance(rd_ptr, depth);
        end
    end

    generate
        for (genvar g = 0; g < MAX_DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[g] <= '0;
                else if (!enable)
                    mem[g] <= '0;
                else if (push_en && wr_ptr == PTR_W'(g))
                    mem[g] <= push_word;
            end
        end
    endgenerate

    assign head_word = mem[rd_ptr];

endmodule

// File: rtl/crc_wfifo_ctrl.sv
module crc_wfifo_ctrl
    import crc_wfifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] depth,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_en,
    output logic             pop_en,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             overflow
);

    fill_state_t      state_q, state_n;
    logic [CNT_W-1:0] count_q, count_n;
    logic             ovf_q;

    always_comb begin
        push_en = enable && push_req && (state_q != ST_FULL);
        pop_en  = enable && pop_req && (state_q == ST_PART || state_q == ST_FULL);
        count_n = count_q + CNT_W'(push_en) - CNT_W'(pop_en);
    end

    always_comb begin
        state_n = state_q;
        if (!enable) begin
            state_n = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_n = push_en ? ST_PART : ST_EMPTY;
                ST_EMPTY: state_n = push_en ? ST_PART : ST_EMPTY;
                ST_PART: begin
                    if (count_n == '0)
                        state_n = ST_EMPTY;
                    else if (count_n == depth)
                        state_n = ST_FULL;
                    else
                        state_n = ST_PART;
                end
                ST_FULL:  state_n = pop_en ? ST_PART : ST_FULL;
                default:  state_n = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            count_q <= enable ? count_n : '0;
            if (!enable)
                ovf_q <= 1'b0;
            else if (push_req && state_q == ST_FULL)
                ovf_q <= 1'b1;
        end
    end

    always_comb begin
        full     = 1'b0;
        empty    = 1'b0;
        unique case (state_q)
            ST_OFF:   empty = 1'b1;
            ST_EMPTY: empty = 1'b1;
            ST_PART:  ;
            ST_FULL:  full  = 1'b1;
            default:  empty = 1'b1;
        endcase
        count    = count_q;
        overflow = ovf_q;
    end

endmodule

// File: rtl/crc_wfifo.sv
module crc_wfifo
    import crc_wfifo_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [CFG_W-1:0]      width_cfg,
    input  logic                  wr_en,
    input  logic [LANE_IDX_W-1:0] wr_lane,
    input  logic [LANE_W-1:0]     wr_byte,
    input  logic                  pop,
    output logic [DATA_W-1:0]     rd_data,
    output logic [CNT_W-1:0]      word_count,
    output logic                  full,
    output logic                  empty,
    output logic                  overflow
);

    logic [CNT_W-1:0]  depth;
    logic              push_req, push_en, pop_en;
    logic [DATA_W-1:0] push_word, head_word;

    assign depth = depth_of(width_cfg);

    crc_wfifo_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .width_cfg (width_cfg),
        .wr_en     (wr_en),
        .wr_lane   (wr_lane),
        .wr_byte   (wr_byte),
        .push_req  (push_req),
        .push_word (push_word)
    );

    crc_wfifo_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .depth    (depth),
        .push_req (push_req),
        .pop_req  (pop),
        .push_en  (push_en),
        .pop_en   (pop_en),
        .count    (word_count),
        .full     (full),
        .empty    (empty),
        .overflow (overflow)
    );

    crc_wfifo_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .depth     (depth),
        .push_en   (push_en),
        .push_word (push_word),
        .pop_en    (pop_en),
        .head_word (head_word)
    );

    assign rd_data = empty ? '0 : head_word;

endmodule

// File: rtl/crc_wfifo_chk.sv
module crc_wfifo_chk
    import crc_wfifo_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable,
    input logic [CFG_W-1:0]      width_cfg,
    input logic                  wr_en,
    input logic [LANE_IDX_W-1:0] wr_lane,
    input logic                  pop,
    input logic [DATA_W-1:0]     rd_data,
    input logic [CNT_W-1:0]      word_count,
    input logic                  full,
    input logic                  empty,
    input logic                  overflow
);

    logic push_try;
    assign push_try = wr_en && (wr_lane == top_lane(width_cfg));

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R5

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (word_count == '0)); // R5

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (word_count <= depth_of(width_cfg))); // R4

    AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && push_try && !full && !pop) |=> (word_count == $past(word_count) + 1'b1)); // R3

    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pop && !empty && !push_try) |=> (word_count == $past(word_count) - 1'b1)); // R6

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && full && push_try) |=> overflow); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && overflow) |=> overflow); // R9

    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (word_count == '0 && empty && !full && !overflow)); // R8

    AST_EMPTY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rd_data == '0)); // R6

    AST_WIDTH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> ((rd_data & ~width_mask(width_cfg)) == '0)); // R1

endmodule

bind crc_wfifo crc_wfifo_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .width_cfg  (width_cfg),
    .wr_en      (wr_en),
    .wr_lane    (wr_lane),
    .pop        (pop),
    .rd_data    (rd_data),
    .word_count (word_count),
    .full       (full),
    .empty      (empty),
    .overflow   (overflow)
);

// File: tb/test_crc_wfifo.sv
`timescale 1ns/1ps
module test_crc_wfifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [4:0]  width_cfg = 5'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_lane = 2'd0;
    logic [7:0]  wr_byte = 8'd0;
    logic        pop = 1'b0;
    logic [31:0] rd_data;
    logic [4:0]  word_count;
    logic        full, empty, overflow;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_q[$];
    logic [31:0] m_stage = '0;
    logic        m_ovf = 1'b0;

    always #10 clk = ~clk;

    crc_wfifo i_crc_wfifo (
        .clk(clk), .rst_n(rst_n), .enable(enable), .width_cfg(width_cfg),
        .wr_en(wr_en), .wr_lane(wr_lane), .wr_byte(wr_byte), .pop(pop),
        .rd_data(rd_data), .word_count(word_count), .full(full),
        .empty(empty), .overflow(overflow)
    );

    function automatic int b_depth(input logic [4:0] c);
        if (c >= 5'd16) return 4;
        if (c >= 5'd8)  return 8;
        return 16;
    endfunction

    function automatic logic [31:0] b_mask(input logic [4:0] c);
        return (c == 5'd31) ? 32'hFFFF_FFFF : ((32'd1 << (c + 1)) - 32'd1);
    endfunction

    function automatic logic [1:0] b_top(input logic [4:0] c);
        return c[4:3];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R3 count", 32'(word_count), 32'(m_q.size()));
        check("R4 full", 32'(full), 32'(m_q.size() == b_depth(width_cfg)));
        check("R5 empty", 32'(empty), 32'(m_q.size() == 0));
        check("R6 rd_data", rd_data, (m_q.size() == 0) ? 32'd0 : m_q[0]);
        check("R9 overflow", 32'(overflow), 32'(m_ovf));
    endtask

    // Drive one cycle at the falling edge, advance the model, compare one edge later.
    task automatic step(input logic we, input logic [1:0] ln, input logic [7:0] by, input logic pp);
        int d;
        int pre;
        logic [1:0]  tl;
        logic [31:0] mk, merged;
        wr_en = we; wr_lane = ln; wr_byte = by; pop = pp;
        if (!enable) begin
            m_q.delete(); m_stage = '0; m_ovf = 1'b0;
        end else begin
            d = b_depth(width_cfg); tl = b_top(width_cfg); mk = b_mask(width_cfg);
            pre = m_q.size();
            merged = m_stage;
            merged[ln*8 +: 8] = by & mk[ln*8 +: 8];
            if (we && ln == tl) begin
                if (pre < d) m_q.push_back(merged & mk);
                else m_ovf = 1'b1;
                m_stage = '0;
            end else if (we && ln < tl) begin
                m_stage = merged;
            end
            if (pp && pre > 0) void'(m_q.pop_front());
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; pop = 1'b0;
        compare_all();
    endtask

    task automatic idle(); step(1'b0, 2'd0, 8'd0, 1'b0); endtask

    task automatic reconfig(input logic [4:0] c);
        enable = 1'b0; idle();
        width_cfg = c; idle();
        enable = 1'b1; idle();
    endtask

    task automatic push_word(input logic [31:0] w);
        for (int l = 0; l <= int'(b_top(width_cfg)); l++)
            step(1'b1, 2'(l), w[l*8 +: 8], 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 count", 32'(word_count), 32'd0);
        check("R11 empty", 32'(empty), 32'd1);
        check("R11 full", 32'(full), 32'd0);
        check("R11 overflow", 32'(overflow), 32'd0);
        check("R11 rd_data", rd_data, 32'd0);
        rst_n = 1'b1;
        idle();

        // R2: 24-bit word, top lane 2
        reconfig(5'd23);
        step(1'b1, 2'd0, 8'h11, 1'b0);
        check("R2 staged lane0", 32'(word_count), 32'd0);
        step(1'b1, 2'd1, 8'h22, 1'b0);
        step(1'b1, 2'd3, 8'hFF, 1'b0);
        check("R2 lane above top ignored", 32'(word_count), 32'd0);
        step(1'b1, 2'd2, 8'h33, 1'b0);
        check("R2 complete", rd_data, 32'h0033_2211);
        check("R3 count after write", 32'(word_count), 32'd1);
        step(1'b1, 2'd2, 8'h44, 1'b1);
        check("R2 stage cleared", rd_data, 32'h0044_0000);
        check("R10 push+pop count", 32'(word_count), 32'd1);
        step(1'b0, 2'd0, 8'h00, 1'b1);
        step(1'b0, 2'd0, 8'h00, 1'b1);
        check("R6 pop on empty", 32'(word_count), 32'd0);

        // R1: 25-bit word, only bit 0 of lane 3 kept
        reconfig(5'd24);
        push_word(32'hFFFF_FFFF);
        check("R1 25-bit mask", rd_data, 32'h01FF_FFFF);
        reconfig(5'd4);
        step(1'b1, 2'd0, 8'hFF, 1'b0);
        check("R1 5-bit mask", rd_data, 32'h0000_001F);

        // R4/R9/R7/R10 at depth 16
        reconfig(5'd7);
        for (int i = 0; i < 16; i++) push_word(32'(i + 8'hA0));
        check("R4 full at 16", 32'(full), 32'd1);
        push_word(32'h55);
        check("R9 overflow set", 32'(overflow), 32'd1);
        check("R9 count kept", 32'(word_count), 32'd16);
        check("R7 head oldest", rd_data, 32'hA0);
        step(1'b1, 2'd0, 8'h77, 1'b1);
        check("R10 full push+pop", 32'(word_count), 32'd15);
        check("R7 second word", rd_data, 32'hA1);
        check("R9 sticky", 32'(overflow), 32'd1);
        for (int i = 0; i < 15; i++) step(1'b0, 2'd0, 8'h0, 1'b1);

        // R4 depths 8 and 4
        reconfig(5'd15);
        for (int i = 0; i < 8; i++) push_word(32'(16'h1234 + i));
        check("R4 full at 8", 32'(full), 32'd1);
        reconfig(5'd31);
        for (int i = 0; i < 4; i++) push_word(32'hDEAD_0000 + 32'(i));
        check("R4 full at 4", 32'(full), 32'd1);

        // R8 flush, writes ignored while disabled, stage cleared
        step(1'b1, 2'd0, 8'h99, 1'b0);
        enable = 1'b0;
        step(1'b1, 2'd3, 8'h12, 1'b0);
        check("R8 flushed", 32'(word_count), 32'd0);
        check("R8 ovf cleared", 32'(overflow), 32'd0);
        enable = 1'b1;
        step(1'b1, 2'd1, 8'h01, 1'b0); step(1'b1, 2'd2, 8'h02, 1'b0);
        step(1'b1, 2'd3, 8'h03, 1'b0);
        check("R8 stage cleared", rd_data, 32'h0302_0100);

        // Constrained random over several widths
        foreach (m_q[i]) ;
        for (int k = 0; k < 10; k++) begin
            logic [4:0] c;
            c = (k < 7) ? 5'(k * 5) : 5'($urandom_range(0, 31));
            reconfig(c);
            for (int n = 0; n < 400; n++)
                step($urandom_range(0, 9) < 6, 2'($urandom_range(0, 3)),
                     8'($urandom), $urandom_range(0, 9) < 3);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule